// File: doc/BRIEF.md
# Prioritized Local Interrupt Acceptor

This block sits beside a processor core and collects the interrupt requests addressed to it. Each request names an 8-bit vector, a 3-bit delivery mode and a level/edge flag. Ordinary vectored requests are stored in a 256-bit pending array, with a matching 256-bit trigger-mode array. Vectors the core has taken but not yet retired are tracked in a 256-bit in-service array. The special delivery modes (system-management, non-maskable, init, start-up and external) bypass the arrays. Each of them has a one-deep pending latch that holds its vector.

Each cycle the block picks the single interrupt the core should take and presents it on a valid/ready pair. The pick follows a fixed priority order. Vectored interrupts are also gated by the interrupt-enable flag, by the highest in-service vector and by the priority class of the task priority. When the core raises ready while valid is high, the presented interrupt is taken. A separate end-of-interrupt strobe retires the highest in-service vector.

The request input is a valid/ready stream whose ready is held at 1 at all times. A request is consumed on every clock edge where valid is high, and it is never stalled. On the output side, the presented interrupt stays put until it is taken or until a higher-priority event replaces it. The core may hold ready low for as long as it likes.

Top module: `intacc_core`

## Requirements
- R1: After reset, irq_valid is 0, nothing is pending or in service, and req_ready is 1.
- R2: A request with mode 0 (fixed) or 1 (lowest priority) sets the pending bit of its vector. The vector is presented with irq_kind 6 one cycle after the request edge, provided R4, R5 and R8 allow it.
- R3: When a pending bit is newly set, its trigger bit takes req_level. A request for a vector that is already pending is merged, and its level is ignored. irq_level shows the trigger bit of the presented vector.
- R4: A vectored interrupt (kind 6) or an external interrupt (kind 5) is presented only while irq_en is 1.
- R5: A vectored interrupt is presented only if bits 7:4 of the highest pending vector are strictly greater than bits 7:4 of irq_tpr.
- R6: Taking a kind-6 interrupt sets its in-service bit and clears its pending bit. The next-highest pending vector becomes the candidate.
- R7: An eoi pulse clears the highest in-service bit. If no bit is in service, eoi has no effect.
- R8: A vectored interrupt is presented only if the highest pending vector is greater than the highest in-service vector, or if nothing is in service.
- R9: The special modes are mode 2 (kind 1), mode 4 (kind 2), mode 5 (kind 3), mode 6 (kind 4) and mode 7 (kind 5). The presentation priority is kind 1, then 2, 3, 4, 5, then 6. irq_vector carries the latched vector of the kind being presented.
- R10: Each special mode holds at most one pending request. A second request of the same mode that arrives while one is pending is dropped, and the first vector is kept.
- R11: Kinds 1 to 4 are presented even when irq_en is 0.
- R12: A start-up request (mode 6) is accepted only while the started flag is clear. Taking kind 4 sets the flag, and taking kind 3 clears it. The flag is 0 after reset.
- R13: A request with mode 3 is discarded and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Always 1; requests are never stalled |
| req_mode | input | 3 | Delivery mode code |
| req_vector | input | 8 | Request vector |
| req_level | input | 1 | 1 for a level request, 0 for an edge request |
| irq_en | input | 1 | Processor interrupt-enable flag |
| irq_tpr | input | 8 | Task priority |
| irq_valid | output | 1 | An interrupt is offered to the core |
| irq_ready | input | 1 | Core takes the offered interrupt |
| irq_kind | output | 3 | Kind code of the offered interrupt (0 when none) |
| irq_vector | output | 8 | Vector of the offered interrupt |
| irq_level | output | 1 | Trigger bit of the offered vectored interrupt |
| eoi | input | 1 | End-of-interrupt pulse |

## Verification
A request, a take or an eoi updates registers on the clock edge where it is seen. The offered interrupt is then decoded combinationally from those registers, so every result is due in the cycle after that edge. irq_en and irq_tpr act within the same cycle, because they only gate the combinational selection. The bench drives all inputs on the falling edge and holds each one for exactly one rising edge. It reads the outputs on the next falling edge, which falls after the single register stage and before the next update.

// File: rtl/intacc_pkg.sv
package intacc_pkg;
  localparam int NSLOT = 5;  // special latches, index = priority rank

  localparam logic [2:0] K_NONE = 3'd0;
  localparam logic [2:0] K_VEC  = 3'd6;

  localparam logic [2:0] M_FIXED  = 3'd0;
  localparam logic [2:0] M_LOWEST = 3'd1;

  localparam int SLOT_INIT  = 2;
  localparam int SLOT_START = 3;
  localparam int SLOT_EXT   = 4;

  function automatic logic [2:0] mode_of_slot(input int s);
    case (s)
      0:       return 3'd2;
      1:       return 3'd4;
      2:       return 3'd5;
      3:       return 3'd6;
      default: return 3'd7;
    endcase
  endfunction

  function automatic logic [2:0] kind_of_slot(input int s);
    return 3'(s + 1);
  endfunction
endpackage

// File: rtl/intacc_prio_enc.sv
module intacc_prio_enc #(
  parameter int N = 256,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     vec,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = 0; i < N; i++) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/intacc_special.sv
module intacc_special
  import intacc_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_fire,
  input  logic [2:0]                   req_mode,
  input  logic [VEC_W-1:0]             req_vector,
  input  logic                         take_fire,
  input  logic [2:0]                   take_kind,
  output logic [NSLOT-1:0]             pend,
  output logic [NSLOT-1:0][VEC_W-1:0]  slot_vec
);
  logic started_q;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    localparam logic [2:0] MODE = mode_of_slot(g);
    localparam logic [2:0] KIND = kind_of_slot(g);
    logic pend_q;
    logic [VEC_W-1:0] vec_q;
    logic gate_ok;
    logic hit, clr;

    if (g == SLOT_START) begin : g_gate
      assign gate_ok = !started_q;
    end else begin : g_nogate
      assign gate_ok = 1'b1;
    end

    assign hit = req_fire && (req_mode == MODE) && !pend_q && gate_ok;
    assign clr = take_fire && (take_kind == KIND);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend_q <= 1'b0;
        vec_q  <= '0;
      end else if (clr) begin
        pend_q <= 1'b0;
      end else if (hit) begin
        pend_q <= 1'b1;
        vec_q  <= req_vector;
      end
    end

    assign pend[g]     = pend_q;
    assign slot_vec[g] = vec_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      started_q <= 1'b0;
    else if (take_fire && take_kind == kind_of_slot(SLOT_INIT))
      started_q <= 1'b0;
    else if (take_fire && take_kind == kind_of_slot(SLOT_START))
      started_q <= 1'b1;
  end
endmodule

// File: rtl/intacc_core.sv
module intacc_core
  import intacc_pkg::*;
#(
  parameter int VEC_W = 8,
  parameter int CLS_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [2:0]       req_mode,
  input  logic [VEC_W-1:0] req_vector,
  input  logic             req_level,
  input  logic             irq_en,
  input  logic [VEC_W-1:0] irq_tpr,
  output logic             irq_valid,
  input  logic             irq_ready,
  output logic [2:0]       irq_kind,
  output logic [VEC_W-1:0] irq_vector,
  output logic             irq_level,
  input  logic             eoi
);
  localparam int NUM_VEC = 2 ** VEC_W;
  localparam int CLS_LO  = VEC_W - CLS_W;

  logic [NUM_VEC-1:0] irr_q, isr_q, tmr_q;
  logic [NUM_VEC-1:0] irr_n, isr_n, tmr_n;
  logic               irr_any, isr_any;
  logic [VEC_W-1:0]   irr_top, isr_top;
  logic [NSLOT-1:0]   spec_pend;
  logic [NSLOT-1:0][VEC_W-1:0] spec_vec;
  logic               req_fire, take_fire, vec_ok, vec_req;

  assign req_ready = 1'b1;
  assign req_fire  = req_valid && req_ready;
  assign vec_req   = req_fire && (req_mode == M_FIXED || req_mode == M_LOWEST);

  intacc_prio_enc #(.N(NUM_VEC)) u_irr_enc (.vec(irr_q), .found(irr_any), .idx(irr_top));
  intacc_prio_enc #(.N(NUM_VEC)) u_isr_enc (.vec(isr_q), .found(isr_any), .idx(isr_top));

  intacc_special #(.VEC_W(VEC_W)) u_spec (
    .clk(clk), .rst_n(rst_n), .req_fire(req_fire), .req_mode(req_mode),
    .req_vector(req_vector), .take_fire(take_fire), .take_kind(irq_kind),
    .pend(spec_pend), .slot_vec(spec_vec)
  );

  assign vec_ok = irq_en && irr_any && (!isr_any || irr_top > isr_top) &&
                  (irr_top[VEC_W-1:CLS_LO] > irq_tpr[VEC_W-1:CLS_LO]);

  // fixed priority selection: slots 0..3 unmaskable, slot 4 needs enable
  always_comb begin
    irq_kind   = K_NONE;
    irq_vector = '0;
    irq_level  = 1'b0;
    if (vec_ok) begin
      irq_kind   = K_VEC;
      irq_vector = irr_top;
      irq_level  = tmr_q[irr_top];
    end
    if (irq_en && spec_pend[SLOT_EXT]) begin
      irq_kind   = kind_of_slot(SLOT_EXT);
      irq_vector = spec_vec[SLOT_EXT];
      irq_level  = 1'b0;
    end
    for (int s = SLOT_EXT - 1; s >= 0; s--) begin
      if (spec_pend[s]) begin
        irq_kind   = kind_of_slot(s);
        irq_vector = spec_vec[s];
        irq_level  = 1'b0;
      end
    end
  end

  assign irq_valid = (irq_kind != K_NONE);
  assign take_fire = irq_valid && irq_ready;

  always_comb begin
    irr_n = irr_q;
    isr_n = isr_q;
    tmr_n = tmr_q;
    if (eoi && isr_any) isr_n[isr_top] = 1'b0;
    if (take_fire && irq_kind == K_VEC) begin
      irr_n[irr_top] = 1'b0;
      isr_n[irr_top] = 1'b1;
    end
    if (vec_req && !irr_q[req_vector]) begin
      irr_n[req_vector] = 1'b1;
      tmr_n[req_vector] = req_level;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irr_q <= '0;
      isr_q <= '0;
      tmr_q <= '0;
    end else begin
      irr_q <= irr_n;
      isr_q <= isr_n;
      tmr_q <= tmr_n;
    end
  end
endmodule

// File: rtl/intacc_chk.sv
module intacc_chk
  import intacc_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  req_valid,
  input logic [2:0]            req_mode,
  input logic                  irq_en,
  input logic [VEC_W-1:0]      irq_tpr,
  input logic                  irq_valid,
  input logic                  irq_ready,
  input logic [2:0]            irq_kind,
  input logic [VEC_W-1:0]      irq_vector,
  input logic                  eoi,
  input logic                  smi_pend,
  input logic [2**VEC_W-1:0]   irr_q,
  input logic [2**VEC_W-1:0]   isr_q
);
  // R4
  en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_en && irq_valid) |-> (irq_kind != K_VEC && irq_kind != 3'd5));

  // R5
  tpr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_kind == K_VEC) |->
      (irq_vector[VEC_W-1 -: 4] > irq_tpr[VEC_W-1 -: 4]));

  // R9
  smi_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smi_pend |-> (irq_valid && irq_kind == 3'd1));

  // R6
  take_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_ready && irq_kind == K_VEC) |=> isr_q[$past(irq_vector)]);

  // R7
  eoi_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && (|isr_q) && !(irq_valid && irq_ready && irq_kind == K_VEC)) |=>
      ($countones(isr_q) == $past($countones(isr_q)) - 1));

  // R13
  rsvd_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mode == 3'd3 && !(irq_valid && irq_ready) && !eoi) |=>
      ($stable(irr_q) && $stable(isr_q)));
endmodule

bind intacc_core intacc_chk #(.VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
  .irq_en(irq_en), .irq_tpr(irq_tpr), .irq_valid(irq_valid),
  .irq_ready(irq_ready), .irq_kind(irq_kind), .irq_vector(irq_vector),
  .eoi(eoi), .smi_pend(spec_pend[0]), .irr_q(irr_q), .isr_q(isr_q)
);

// File: tb/intacc_core_tb.sv
module intacc_core_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [2:0] req_mode = 3'd0;
  logic [7:0] req_vector = 8'd0;
  logic       req_level = 1'b0;
  logic       irq_en = 1'b0;
  logic [7:0] irq_tpr = 8'd0;
  logic       irq_valid;
  logic       irq_ready = 1'b0;
  logic [2:0] irq_kind;
  logic [7:0] irq_vector;
  logic       irq_level;
  logic       eoi = 1'b0;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intacc_core u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .req_vector(req_vector), .req_level(req_level),
    .irq_en(irq_en), .irq_tpr(irq_tpr), .irq_valid(irq_valid),
    .irq_ready(irq_ready), .irq_kind(irq_kind), .irq_vector(irq_vector),
    .irq_level(irq_level), .eoi(eoi)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // offered interrupt as {valid, kind, vector}
  function automatic logic [31:0] offer();
    return {20'd0, irq_valid, irq_kind, irq_vector};
  endfunction

  function automatic logic [31:0] exp_offer(input logic [2:0] k, input logic [7:0] v);
    return {20'd0, 1'b1, k, v};
  endfunction

  localparam logic [31:0] NONE = 32'd0;

  task automatic send(input logic [2:0] m, input logic [7:0] v, input logic lvl);
    @(negedge clk);
    req_valid = 1'b1; req_mode = m; req_vector = v; req_level = lvl;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic take();
    @(negedge clk);
    irq_ready = 1'b1;
    @(negedge clk);
    irq_ready = 1'b0;
  endtask

  task automatic retire();
    @(negedge clk);
    eoi = 1'b1;
    @(negedge clk);
    eoi = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 valid", {31'd0, irq_valid}, 32'd0);
    chk("R1 ready", {31'd0, req_ready}, 32'd1);
    irq_en = 1'b1;
    @(negedge clk);
    chk("R1 nothing pending", offer(), NONE);
  endtask

  task automatic t_vectored();
    send(3'd0, 8'h45, 1'b0);
    chk("R2 fixed offered", offer(), exp_offer(3'd6, 8'h45));
    chk("R3 edge trigger", {31'd0, irq_level}, 32'd0);
    send(3'd1, 8'h45, 1'b1);
    chk("R3 merged level ignored", {31'd0, irq_level}, 32'd0);
    send(3'd1, 8'h80, 1'b1);
    chk("R2 lowest offered top", offer(), exp_offer(3'd6, 8'h80));
    chk("R3 level trigger", {31'd0, irq_level}, 32'd1);
  endtask

  task automatic t_gating();
    irq_en = 1'b0;
    @(negedge clk);
    chk("R4 disabled", offer(), NONE);
    irq_en = 1'b1;
    irq_tpr = 8'h8F;
    @(negedge clk);
    chk("R5 equal class blocked", offer(), NONE);
    irq_tpr = 8'h7F;
    @(negedge clk);
    chk("R5 higher class passes", offer(), exp_offer(3'd6, 8'h80));
    irq_tpr = 8'h00;
  endtask

  task automatic t_service();
    take();
    chk("R8 lower blocked by service", offer(), NONE);
    send(3'd0, 8'h80, 1'b0);
    chk("R8 equal blocked by service", offer(), NONE);
    retire();
    chk("R7 eoi unblocks", offer(), exp_offer(3'd6, 8'h80));
    take();
    chk("R6 next candidate blocked", offer(), NONE);
    retire();
    chk("R6 next candidate", offer(), exp_offer(3'd6, 8'h45));
    take();
    retire();
    chk("R6 drained", offer(), NONE);
    retire();
    send(3'd0, 8'h30, 1'b0);
    chk("R7 eoi idle no effect", offer(), exp_offer(3'd6, 8'h30));
    take();
    retire();
  endtask

  task automatic t_special_order();
    send(3'd7, 8'h20, 1'b0);
    send(3'd0, 8'h90, 1'b0);
    send(3'd4, 8'h02, 1'b0);
    send(3'd2, 8'h03, 1'b0);
    chk("R9 smi first", offer(), exp_offer(3'd1, 8'h03));
    take();
    chk("R9 nmi second", offer(), exp_offer(3'd2, 8'h02));
    take();
    chk("R9 ext before vector", offer(), exp_offer(3'd5, 8'h20));
    take();
    chk("R9 vector last", offer(), exp_offer(3'd6, 8'h90));
    take();
    retire();
  endtask

  task automatic t_dup_and_mask();
    irq_en = 1'b0;
    send(3'd4, 8'h05, 1'b0);
    send(3'd4, 8'h06, 1'b0);
    chk("R11 nmi while disabled", offer(), exp_offer(3'd2, 8'h05));
    chk("R10 duplicate dropped", offer(), exp_offer(3'd2, 8'h05));
    take();
    chk("R10 no second nmi", offer(), NONE);
    send(3'd7, 8'h21, 1'b0);
    chk("R4 ext held while disabled", offer(), NONE);
    irq_en = 1'b1;
    @(negedge clk);
    chk("R4 ext after enable", offer(), exp_offer(3'd5, 8'h21));
    take();
  endtask

  task automatic t_startup();
    send(3'd6, 8'h11, 1'b0);
    send(3'd5, 8'h22, 1'b0);
    chk("R9 init before startup", offer(), exp_offer(3'd3, 8'h22));
    take();
    chk("R12 startup offered", offer(), exp_offer(3'd4, 8'h11));
    take();
    send(3'd6, 8'h33, 1'b0);
    chk("R12 startup refused once started", offer(), NONE);
    irq_en = 1'b0;
    send(3'd5, 8'h23, 1'b0);
    chk("R11 init while disabled", offer(), exp_offer(3'd3, 8'h23));
    take();
    irq_en = 1'b1;
    send(3'd6, 8'h44, 1'b0);
    chk("R12 startup after init", offer(), exp_offer(3'd4, 8'h44));
    take();
  endtask

  task automatic t_reserved();
    send(3'd3, 8'h99, 1'b1);
    chk("R13 reserved discarded", offer(), NONE);
    send(3'd0, 8'h50, 1'b0);
    chk("R13 later request normal", offer(), exp_offer(3'd6, 8'h50));
    take();
    retire();
    chk("R13 idle at end", offer(), NONE);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_vectored();
    t_gating();
    t_service();
    t_special_order();
    t_dup_and_mask();
    t_startup();
    t_reserved();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule